// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block keeps a processor core in reset after a power-on, a brown-out or a wake event until the supply and the clock can be trusted. It can run up to three delay stages in a fixed order. The first is a long power-up delay measured in ticks of a slow timebase. The second is an oscillator start-up count measured in cycles of the block clock. The third is a PLL lock wait, also measured in timebase ticks. The trigger and the selected oscillator mode decide which stages run, and stages that do not apply are skipped.

The external active-low reset pin passes through a two-flop synchronizer. It gates only the run output and never restarts a timer. If the pin is held low until every stage has finished, the core starts running a fixed number of cycles after the pin is released. The stage currently in progress is visible on a status output, so the sequence can be observed from outside the block.

Stage codes on `stage_o`: 0 = done, 1 = power-up delay, 2 = oscillator start-up, 3 = PLL lock wait, 4 = armed. The armed stage lasts one cycle after the power-on pulse ends. Oscillator mode codes on `osc_mode_i`: 0, 1 and 2 are crystal/resonator modes, and 2 is the high-speed crystal mode. Code 3 is an external clock. Codes 4 to 7 are external RC.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_i` is high, `run_o` is 0 and `stage_o` reads 4. After `por_i` falls, `stage_o` leaves 4 on the first clock edge.
- R2: After power-on with `pwrt_dis_i` = 0, the first stage is 1. Stage 1 ends on its PWRT_TICKS-th `tick_i` pulse.
- R3: Stage 2 runs only in modes 0–2 and follows the power-up delay, or follows the armed stage when there is no power-up delay. It lasts exactly OST_CYCLES clock cycles.
- R4: Stage 3 follows stage 2 only in mode 2 with `pll_en_i` = 1. It ends on its PLL_TICKS-th `tick_i` pulse, and stage 0 follows.
- R5: Modes 3–7 never enter stage 2 or stage 3. With `pwrt_dis_i` = 1 in those modes, a power-on goes from stage 4 directly to stage 0.
- R6: A `bor_i` pulse in any stage restarts the sequence at stage 1 from a cleared count, whatever the value of `pwrt_dis_i`.
- R7: A `wake_i` pulse is accepted only in stage 0. It runs the mode's stage 2 and stage 3 and never runs stage 1. In modes 3–7 the stage stays 0 and `run_o` stays 1. A `wake_i` pulse in any other stage has no effect on the stage sequence.
- R8: `run_o` rises on the clock edge after the one that makes the stage 0, provided the synchronized pin is high. `run_o` falls on the edge that accepts a `bor_i` or `wake_i` restart. `core_rst_o` is always the inverse of `run_o`.
- R9: `mclr_n_i` is sampled through two flops. A low pin forces `run_o` low on the third edge and leaves the stage sequence untouched. A release after the sequence has finished raises `run_o` on the third edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; counted in stage 2 |
| por_i | input | 1 | Power-on delay pulse, active high, asynchronous |
| bor_i | input | 1 | Brown-out reset pulse, synchronous |
| wake_i | input | 1 | Wake-from-sleep or clock-switch request, one cycle |
| mclr_n_i | input | 1 | External reset pin, active low, asynchronous |
| pwrt_dis_i | input | 1 | 1 disables the power-up delay on power-on |
| osc_mode_i | input | 3 | Oscillator mode code |
| pll_en_i | input | 1 | PLL enabled |
| tick_i | input | 1 | Slow timebase tick, one cycle wide |
| stage_o | output | 3 | Current stage code |
| run_o | output | 1 | Core may execute |
| core_rst_o | output | 1 | Core held in reset |

## Verification
The assertions assume the mode and PLL configuration stay fixed while stage 2 or stage 3 is in progress. They also assume the pin has a defined level from the first cycle of the power-on pulse. The bench changes the configuration only while the block rests in stage 0 or during the power-on pulse, at the same moment it applies a trigger, and it drives the pin high from time zero. Wake requests are single-cycle pulses. They are issued either from stage 0 or deliberately inside a power-up delay, which always lasts several ticks after a brown-out, so the wake pulse cannot fall on the hand-over into stage 0.

// File: rtl/rst_timeout_seq.sv
`timescale 1ns/1ps
module rst_timeout_seq #(
  parameter int PWRT_TICKS = 72,
  parameter int PLL_TICKS  = 2,
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       wake_i,
  input  logic       mclr_n_i,
  input  logic       pwrt_dis_i,
  input  logic [2:0] osc_mode_i,
  input  logic       pll_en_i,
  input  logic       tick_i,
  output logic [2:0] stage_o,
  output logic       run_o,
  output logic       core_rst_o
);
  localparam logic [2:0] S_DONE = 3'd0;
  localparam logic [2:0] S_PWRT = 3'd1;
  localparam logic [2:0] S_OST  = 3'd2;
  localparam logic [2:0] S_PLL  = 3'd3;
  localparam logic [2:0] S_ARM  = 3'd4;
  localparam int MAX_AB = (PWRT_TICKS > PLL_TICKS) ? PWRT_TICKS : PLL_TICKS;
  localparam int MAXC   = (OST_CYCLES > MAX_AB) ? OST_CYCLES : MAX_AB;
  localparam int CW     = $clog2(MAXC + 1);

  logic [2:0]    stage_q, stage_d;
  logic [CW-1:0] cnt_q;
  logic          cnt_clr, cnt_inc;
  logic [1:0]    pin_q;
  logic          run_q;
  logic          xtal, pll_need, pw_end, ost_end, pll_end;
  logic [2:0]    after_pwrt, after_ost;

  assign xtal       = osc_mode_i <= 3'd2;
  assign pll_need   = (osc_mode_i == 3'd2) && pll_en_i;
  assign after_ost  = pll_need ? S_PLL : S_DONE;
  assign after_pwrt = xtal ? S_OST : S_DONE;
  assign pw_end     = tick_i && (cnt_q == CW'(PWRT_TICKS - 1));
  assign pll_end    = tick_i && (cnt_q == CW'(PLL_TICKS - 1));
  assign ost_end    = cnt_q == CW'(OST_CYCLES - 1);
  assign cnt_inc    = (stage_q == S_OST) ||
                      (((stage_q == S_PWRT) || (stage_q == S_PLL)) && tick_i);

  always_comb begin
    stage_d = stage_q;
    cnt_clr = 1'b0;
    if (bor_i) begin
      stage_d = S_PWRT;
      cnt_clr = 1'b1;
    end else begin
      case (stage_q)
        S_ARM: begin
          stage_d = pwrt_dis_i ? after_pwrt : S_PWRT;
          cnt_clr = 1'b1;
        end
        S_PWRT: if (pw_end) begin
          stage_d = after_pwrt;
          cnt_clr = 1'b1;
        end
        S_OST: if (ost_end) begin
          stage_d = after_ost;
          cnt_clr = 1'b1;
        end
        S_PLL: if (pll_end) begin
          stage_d = S_DONE;
          cnt_clr = 1'b1;
        end
        S_DONE: if (wake_i) begin
          stage_d = after_pwrt;
          cnt_clr = 1'b1;
        end
        default: begin
          stage_d = S_ARM;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      stage_q <= S_ARM;
      cnt_q   <= '0;
      pin_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      if (cnt_clr)      cnt_q <= '0;
      else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
      pin_q   <= {pin_q[0], mclr_n_i};
      run_q   <= (stage_q == S_DONE) && (stage_d == S_DONE) && pin_q[1];
    end
  end

  assign stage_o    = stage_q;
  assign run_o      = run_q;
  assign core_rst_o = ~run_q;
endmodule

// File: rtl/rst_timeout_seq_chk.sv
`timescale 1ns/1ps
module rst_timeout_seq_chk (
  input logic       clk,
  input logic       por_i,
  input logic       bor_i,
  input logic       wake_i,
  input logic       mclr_n_i,
  input logic [2:0] osc_mode_i,
  input logic       pll_en_i,
  input logic [2:0] stage_o,
  input logic       run_o,
  input logic       core_rst_o
);
  AST_ARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (por_i)
    stage_o == 3'd4 |=> stage_o != 3'd4); // R1
  AST_OST_XTAL_ONLY: assert property (@(posedge clk) disable iff (por_i)
    stage_o == 3'd2 |-> osc_mode_i <= 3'd2); // R5
  AST_PLL_HS_ONLY: assert property (@(posedge clk) disable iff (por_i)
    stage_o == 3'd3 |-> (osc_mode_i == 3'd2) && pll_en_i); // R4
  AST_BOR_RESTART: assert property (@(posedge clk) disable iff (por_i)
    bor_i |=> (stage_o == 3'd1) && !run_o); // R6
  AST_WAKE_NO_PWRT: assert property (@(posedge clk) disable iff (por_i)
    (stage_o == 3'd0) && wake_i && !bor_i |=> stage_o != 3'd1); // R7
  AST_RUN_AFTER_DONE: assert property (@(posedge clk) disable iff (por_i)
    $rose(run_o) |-> $past(stage_o) == 3'd0); // R8
  AST_RST_INVERSE: assert property (@(posedge clk) disable iff (por_i)
    core_rst_o == !run_o); // R8
  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (por_i)
    !$past(mclr_n_i, 3) |-> !run_o); // R9
endmodule

bind rst_timeout_seq rst_timeout_seq_chk u_chk (.*);

// File: tb/test_rst_timeout_seq.sv
`timescale 1ns/1ps
module test_rst_timeout_seq;
  localparam int P_PWRT = 4;
  localparam int P_PLL  = 3;
  localparam int P_OST  = 16;

  logic clk = 0, por_i = 1, bor_i = 0, wake_i = 0, mclr_n_i = 1;
  logic pwrt_dis_i = 0, pll_en_i = 0, tick_i = 0;
  logic [2:0] osc_mode_i = 3'd0;
  logic [2:0] stage_o;
  logic run_o, core_rst_o;
  int n_run = 0, n_fail = 0;
  int exp_q[$];

  rst_timeout_seq #(.PWRT_TICKS(P_PWRT), .PLL_TICKS(P_PLL), .OST_CYCLES(P_OST)) i_rst_timeout_seq (
    .clk(clk), .por_i(por_i), .bor_i(bor_i), .wake_i(wake_i), .mclr_n_i(mclr_n_i),
    .pwrt_dis_i(pwrt_dis_i), .osc_mode_i(osc_mode_i), .pll_en_i(pll_en_i), .tick_i(tick_i),
    .stage_o(stage_o), .run_o(run_o), .core_rst_o(core_rst_o));

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk); #1;
    tick_i = ($urandom % 3) == 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk); #2;
  endtask

  function automatic void build(input int trig, input int mode, input bit dis, input bit pll);
    bit pw;
    exp_q.delete();
    pw = (trig == 0) ? !dis : (trig == 1);
    if (pw) exp_q.push_back(1);
    if (mode <= 2) exp_q.push_back(2);
    if (mode == 2 && pll) exp_q.push_back(3);
  endfunction

  // trig: 0 power-on, 1 brown-out, 2 wake
  task automatic run_seq(input int trig, input int mode, input bit dis, input bit pll,
                         input bit poke, input bit hold, input string tag);
    int obs[$];
    int last, k, done_k, rise_k, tpw, cost, tpll;
    tpw = 0; cost = 0; tpll = 0; done_k = -1; last = 0;
    step;
    osc_mode_i = 3'(mode); pwrt_dis_i = dis; pll_en_i = pll;
    if (hold) mclr_n_i = 0;
    build(trig, mode, dis, pll);
    if (trig == 0) begin
      por_i = 1;
      for (int i = 0; i < 3; i++) begin
        step;
        chk(run_o == 0 && stage_o == 3'd4, "R1 reset state", {run_o, stage_o}, 4);
      end
      por_i = 0;
      step;
    end else begin
      if (trig == 1) bor_i = 1; else wake_i = 1;
      step;
      bor_i = 0; wake_i = 0;
      if (trig == 1) chk(run_o == 0, "R8 run drops on brown-out", run_o, 0);
    end
    k = 1;
    while (done_k < 0 && k < 5000) begin
      if (stage_o != 3'(last) && stage_o != 3'd0) obs.push_back(int'(stage_o));
      last = stage_o;
      if (stage_o == 3'd1 && tick_i) tpw++;
      if (stage_o == 3'd2) cost++;
      if (stage_o == 3'd3 && tick_i) tpll++;
      if (poke && k == 2) wake_i = 1;
      if (poke && k == 3) wake_i = 0;
      if (stage_o == 3'd0) done_k = k;
      else begin step; k++; end
    end
    wake_i = 0;
    chk(done_k > 0, {tag, " sequence completes"}, done_k, 1);
    chk(obs.size() == exp_q.size(), {tag, " stage count"}, obs.size(), exp_q.size());
    for (int i = 0; i < obs.size() && i < exp_q.size(); i++)
      chk(obs[i] == exp_q[i], {tag, " stage order"}, obs[i], exp_q[i]);
    foreach (exp_q[i]) begin
      if (exp_q[i] == 1) chk(tpw == P_PWRT, "R2 power-up delay ticks", tpw, P_PWRT);
      if (exp_q[i] == 2) chk(cost == P_OST, "R3 start-up cycles", cost, P_OST);
      if (exp_q[i] == 3) chk(tpll == P_PLL, "R4 PLL wait ticks", tpll, P_PLL);
    end
    if (hold) rise_k = 1 << 30;
    else if (trig == 2 && exp_q.size() == 0) rise_k = 0;
    else begin
      rise_k = done_k + 1;
      if (trig == 0 && rise_k < 3) rise_k = 3;
    end
    for (int j = 0; j < 3; j++) begin
      chk(run_o == (k >= rise_k), hold ? "R9 pin holds reset" : "R8 run timing",
          run_o, int'(k >= rise_k));
      chk(stage_o == 3'd0, "R9 stage stays done", stage_o, 0);
      step; k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) step;
    chk(run_o == 0 && core_rst_o == 1, "R1 reset outputs", run_o, 0);
    run_seq(0, 2, 0, 1, 0, 0, "R2 por HS pll");
    run_seq(0, 4, 1, 0, 0, 0, "R5 por RC no delay");
    run_seq(0, 3, 0, 0, 0, 0, "R5 por EC");
    run_seq(1, 3, 1, 0, 0, 0, "R6 bor ignores disable");
    run_seq(2, 2, 0, 1, 0, 0, "R7 wake HS pll");
    run_seq(2, 3, 0, 0, 0, 0, "R7 wake EC");
    run_seq(1, 1, 0, 0, 1, 0, "R7 wake ignored mid-sequence");
    run_seq(1, 0, 0, 0, 0, 1, "R9 pin held low");
    mclr_n_i = 1;
    step; chk(run_o == 0, "R9 release edge 1", run_o, 0);
    step; chk(run_o == 0, "R9 release edge 2", run_o, 0);
    step; chk(run_o == 1, "R9 release edge 3", run_o, 1);
    mclr_n_i = 0;
    step; step; chk(run_o == 1, "R9 assert edge 2", run_o, 1);
    step; chk(run_o == 0 && core_rst_o == 1, "R9 assert edge 3", run_o, 0);
    chk(stage_o == 3'd0, "R9 no timer restart", stage_o, 0);
    mclr_n_i = 1;
    repeat (4) step;
    chk(run_o == 1, "R9 run back", run_o, 1);
    for (int it = 0; it < 24; it++)
      run_seq(int'($urandom % 3), int'($urandom % 8), 1'($urandom), 1'($urandom), 0, 0, "R3 R4 random");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule